// File: doc/BRIEF.md
# Poll Reply Frame Builder

This block assembles the byte stream a reader controller returns to its host while the host clocks poll or command bytes over a serial link. An operation engine loads a reply (status code, secondary byte, byte count). The block works out from the status code which frame layout applies. The serial shifter then pulls the reply out one byte at a time. The block emits each byte, fetches any payload bytes from the engine through an index port, and closes the frame with an 8-bit additive checksum.

Each time select falls, the block takes a snapshot of the frame to be sent. If the engine reports work in progress at that moment, the snapshot is a two-byte busy reply, and the loaded reply stays waiting. A loaded reply stays available until it has been read out in full once. After that, the block falls back to the plain normal-status reply. The SPI bit shifting and the tag operations are outside this block.

Top module: `rfg_top`

## Requirements
- R1: After reset, and before any reply is loaded, a transaction returns 0x00, then checksum 0x00, then 0x00 bytes.
- R2: A status code with bit 7 clear gives a single-byte reply: the code, then a checksum equal to the code. Examples are normal 0x00, format error 0x10 and no tag 0x20.
- R3: If `busy` is high when select falls, the transaction returns 0x01 then 0x01, whatever reply is loaded. The loaded reply is neither lost nor consumed.
- R4: Codes 0x80, 0x86 and 0x90 give a read reply. Its layout is: code, tag type (for example 0x44 or 0x0C), count N, N payload bytes, checksum. Payload byte k is taken from `data_in` while `data_idx` equals k. For example, 80 44 03 44 55 66 is followed by 0xC6.
- R5: Any other code with bit 7 set, other than those named in R4, R6 and R7, gives a write acknowledgement. Its layout is: code, tag type, count, checksum. It carries no payload.
- R6: Codes 0x8F and 0xAF give an error reply. Its layout is: code, one error byte (0x10 to 0x14), checksum.
- R7: Code 0xBA gives a self-test reply. Its layout is: code, result byte (bit0 memory CRC, bit1 RAM, bit2 loopback), 10 payload bytes read at `data_idx` 0 to 9 (2 version bytes, then 8 serial bytes), checksum.
- R8: The checksum is the modulo-256 sum of all earlier bytes of the same reply.
- R9: Every byte clocked after the checksum is 0x00.
- R10: Each fall of select restarts the reply at its first byte. A reply that was only partly read is sent again in full.
- R11: Once a loaded reply has been clocked out through its checksum, the next transaction returns the normal reply 00 00.
- R12: A `byte_adv` pulse while select is high has no effect on the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Host select, active low |
| byte_adv | input | 1 | One-cycle pulse: current byte has been shifted out |
| busy | input | 1 | Operation engine still working |
| rsp_load | input | 1 | Capture a new reply |
| rsp_code | input | 8 | Status code of the reply |
| rsp_info | input | 8 | Tag type, error code or self-test result |
| rsp_count | input | 8 | Payload or transferred byte count |
| data_in | input | 8 | Payload byte at `data_idx` |
| data_idx | output | 8 | Index of the payload byte requested |
| tx_byte | output | 8 | Byte to be shifted out now |

## Verification
Random replies are drawn from every code family, with random secondary bytes, counts and payload contents. Each reply is read one byte at a time through the checksum and two trailing bytes, and compared with a bench model. This separates the five layouts, the payload indexing and the checksum arithmetic. Directed cases cover the following:
- the known read example with its 0xC6 checksum, which pins the summation;
- zero-length and 240-byte reads, which probe the count boundaries;
- a busy poll over a loaded reply, which shows the reply is kept rather than lost;
- a partial read followed by a reread, which tells restart from consumption;
- `byte_adv` pulses with select high, which show that idle advances do not consume the reply.

// File: rtl/rfg_pkg.sv
package rfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        SHP_SINGLE,
        SHP_ERROR,
        SHP_WRITE,
        SHP_READ,
        SHP_TEST
    } shape_e;

    typedef struct packed {
        logic [BYTE_W-1:0] code;
        logic [BYTE_W-1:0] info;
        logic [BYTE_W-1:0] count;
    } frame_t;

    function automatic shape_e classify(input logic [BYTE_W-1:0] code);
        shape_e s;
        if (!code[BYTE_W-1])                          s = SHP_SINGLE;
        else if (code == 8'h8F || code == 8'hAF)      s = SHP_ERROR;
        else if (code == 8'hBA)                       s = SHP_TEST;
        else if (code == 8'h80 || code == 8'h86 ||
                 code == 8'h90)                       s = SHP_READ;
        else                                          s = SHP_WRITE;
        return s;
    endfunction

endpackage

// File: rtl/rfg_shape.sv
module rfg_shape
    import rfg_pkg::*;
#(
    parameter int PTR_W     = 9,
    parameter int TEST_DATA = 10
) (
    input  logic [BYTE_W-1:0] code,
    input  logic [BYTE_W-1:0] count,
    output shape_e            shape,
    output logic [PTR_W-1:0]  sum_pos,
    output logic [PTR_W-1:0]  hdr_len
);
    localparam logic [PTR_W-1:0] HDR_RD = PTR_W'(3);
    localparam logic [PTR_W-1:0] HDR_GN = PTR_W'(2);

    always_comb begin
        shape   = classify(code);
        hdr_len = (shape == SHP_READ) ? HDR_RD : HDR_GN;
        unique case (shape)
            SHP_SINGLE: sum_pos = PTR_W'(1);
            SHP_ERROR:  sum_pos = PTR_W'(2);
            SHP_WRITE:  sum_pos = PTR_W'(3);
            SHP_READ:   sum_pos = HDR_RD + PTR_W'(count);
            default:    sum_pos = HDR_GN + PTR_W'(TEST_DATA);
        endcase
    end
endmodule

// File: rtl/rfg_byte_mux.sv
module rfg_byte_mux
    import rfg_pkg::*;
#(
    parameter int PTR_W = 9
) (
    input  frame_t            frm,
    input  shape_e            shape,
    input  logic [PTR_W-1:0]  sum_pos,
    input  logic [PTR_W-1:0]  hdr_len,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] sum,
    input  logic [BYTE_W-1:0] data_in,
    output logic [BYTE_W-1:0] data_idx,
    output logic [BYTE_W-1:0] tx_byte
);
    logic              has_cnt;
    logic              in_data;
    logic [PTR_W-1:0]  rel;

    always_comb begin
        has_cnt  = (shape == SHP_READ) || (shape == SHP_WRITE);
        in_data  = (shape == SHP_READ || shape == SHP_TEST) &&
                   (ptr >= hdr_len) && (ptr < sum_pos);
        rel      = ptr - hdr_len;
        data_idx = in_data ? rel[BYTE_W-1:0] : '0;
        if (ptr > sum_pos)                    tx_byte = '0;
        else if (ptr == sum_pos)              tx_byte = sum;
        else if (ptr == PTR_W'(0))            tx_byte = frm.code;
        else if (ptr == PTR_W'(1))            tx_byte = frm.info;
        else if (ptr == PTR_W'(2) && has_cnt) tx_byte = frm.count;
        else                                  tx_byte = data_in;
    end
endmodule

// File: rtl/rfg_top.sv
module rfg_top
    import rfg_pkg::*;
#(
    parameter int PTR_W     = 9,
    parameter int TEST_DATA = 10,
    parameter logic [7:0] BUSY_CODE = 8'h01,
    parameter logic [7:0] IDLE_CODE = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_n,
    input  logic        byte_adv,
    input  logic        busy,
    input  logic        rsp_load,
    input  logic [7:0]  rsp_code,
    input  logic [7:0]  rsp_info,
    input  logic [7:0]  rsp_count,
    input  logic [7:0]  data_in,
    output logic [7:0]  data_idx,
    output logic [7:0]  tx_byte
);
    localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};
    localparam frame_t IDLE_FRM = '{code: IDLE_CODE, info: '0, count: '0};
    localparam frame_t BUSY_FRM = '{code: BUSY_CODE, info: '0, count: '0};

    typedef struct packed {
        logic              sel_n;
        logic              from_held;
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] sum;
        frame_t            held;
        frame_t            live;
    } state_t;

    state_t d, q;
    shape_e shape;
    logic [PTR_W-1:0] sum_pos, hdr_len;
    logic sel_fall;

    rfg_shape #(.PTR_W(PTR_W), .TEST_DATA(TEST_DATA)) u_shape (
        .code    (q.live.code),
        .count   (q.live.count),
        .shape   (shape),
        .sum_pos (sum_pos),
        .hdr_len (hdr_len)
    );

    rfg_byte_mux #(.PTR_W(PTR_W)) u_mux (
        .frm      (q.live),
        .shape    (shape),
        .sum_pos  (sum_pos),
        .hdr_len  (hdr_len),
        .ptr      (q.ptr),
        .sum      (q.sum),
        .data_in  (data_in),
        .data_idx (data_idx),
        .tx_byte  (tx_byte)
    );

    always_comb begin
        d        = q;
        d.sel_n  = sel_n;
        sel_fall = q.sel_n && !sel_n;
        if (sel_fall) begin
            d.ptr       = '0;
            d.sum       = '0;
            d.live      = busy ? BUSY_FRM : q.held;
            d.from_held = !busy;
        end else if (!sel_n && byte_adv) begin
            d.sum = q.sum + tx_byte;
            if (q.ptr != PTR_MAX) d.ptr = q.ptr + PTR_W'(1);
            if (q.ptr == sum_pos && q.from_held) begin
                d.held      = IDLE_FRM;
                d.from_held = 1'b0;
            end
        end
        if (rsp_load) begin
            d.held      = '{code: rsp_code, info: rsp_info, count: rsp_count};
            d.from_held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.sel_n     <= 1'b1;
            q.held      <= IDLE_FRM;
            q.live      <= IDLE_FRM;
        end else begin
            q <= d;
        end
    end

    AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel_n && !sel_n) |=> (q.ptr == '0 && q.sum == '0)); // R10
    AST_BUSY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel_n && !sel_n && busy) |=> (tx_byte == BUSY_CODE)); // R3
    AST_IDLE_ADV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && byte_adv) |=> (q.ptr == $past(q.ptr) && q.sum == $past(q.sum))); // R12
    AST_SUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.sel_n && !sel_n && byte_adv) |=> (q.sum == $past(q.sum + tx_byte))); // R8
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_load |=> (q.held.code == $past(rsp_code) && q.held.count == $past(rsp_count))); // R4
endmodule

// File: tb/rfg_top_tb.sv
`timescale 1ns/1ps
module rfg_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, byte_adv = 1'b0, busy = 1'b0, rsp_load = 1'b0;
    logic [7:0] rsp_code = '0, rsp_info = '0, rsp_count = '0;
    logic [7:0] data_in, data_idx, tx_byte;
    logic [7:0] dmem [256];
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign data_in = dmem[data_idx];

    rfg_top u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .byte_adv(byte_adv),
        .busy(busy), .rsp_load(rsp_load), .rsp_code(rsp_code),
        .rsp_info(rsp_info), .rsp_count(rsp_count), .data_in(data_in),
        .data_idx(data_idx), .tx_byte(tx_byte)
    );

    function automatic bit is_read(input logic [7:0] c);
        return c == 8'h80 || c == 8'h86 || c == 8'h90;
    endfunction

    function automatic int csum_at(input logic [7:0] c, input logic [7:0] n);
        if (!c[7])                      return 1;
        if (c == 8'h8F || c == 8'hAF)   return 2;
        if (c == 8'hBA)                 return 12;
        if (is_read(c))                 return 3 + int'(n);
        return 3;
    endfunction

    function automatic logic [7:0] body(input logic [7:0] c, input logic [7:0] inf,
                                        input logic [7:0] n, input int p);
        if (p == 0) return c;
        if (p == 1) return inf;
        if (p == 2 && c[7] && c != 8'hBA && c != 8'h8F && c != 8'hAF) return n;
        return dmem[p - (is_read(c) ? 3 : 2)];
    endfunction

    function automatic logic [7:0] expect_at(input logic [7:0] c, input logic [7:0] inf,
                                             input logic [7:0] n, input int p);
        int l = csum_at(c, n);
        logic [7:0] s = 8'h00;
        if (p > l) return 8'h00;
        if (p < l) return body(c, inf, n, p);
        for (int k = 0; k < l; k++) s = s + body(c, inf, n, k);
        return s;
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic load(input logic [7:0] c, input logic [7:0] inf, input logic [7:0] n);
        @(negedge clk);
        rsp_code = c; rsp_info = inf; rsp_count = n; rsp_load = 1'b1;
        @(negedge clk);
        rsp_load = 1'b0;
    endtask

    task automatic open_sel();
        @(negedge clk); sel_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic close_sel();
        sel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pull(output logic [7:0] b);
        b = tx_byte;
        byte_adv = 1'b1;
        @(negedge clk);
        byte_adv = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] c, input logic [7:0] inf,
                             input logic [7:0] n, input string tag);
        logic [7:0] b;
        int total = csum_at(c, n) + 3;
        open_sel();
        for (int p = 0; p < total; p++) begin
            pull(b);
            if (p == csum_at(c, n))      check(b, expect_at(c, inf, n, p), {tag, "/R8"});
            else if (p > csum_at(c, n))  check(b, 8'h00, {tag, "/R9"});
            else                         check(b, expect_at(c, inf, n, p), tag);
        end
        close_sel();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [15] = '{8'h00, 8'h10, 8'h20, 8'h80, 8'h86, 8'h90, 8'h8F,
                                   8'hA0, 8'hA4, 8'hA6, 8'hA8, 8'hB0, 8'hB4, 8'hAF, 8'hBA};
        logic [7:0] b;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        run_frame(8'h00, 8'h00, 8'h00, "R1");
        load(8'h10, 8'h00, 8'h00); run_frame(8'h10, 8'h00, 8'h00, "R2");
        load(8'h20, 8'h00, 8'h00); run_frame(8'h20, 8'h00, 8'h00, "R2");

        dmem[0] = 8'h44; dmem[1] = 8'h55; dmem[2] = 8'h66;
        load(8'h80, 8'h44, 8'h03);
        open_sel();
        for (int p = 0; p < 7; p++) begin
            pull(b);
            if (p == 6) check(b, 8'hC6, "R4 example checksum");
        end
        close_sel();

        load(8'h86, 8'h0C, 8'h00); run_frame(8'h86, 8'h0C, 8'h00, "R4 zero count");
        for (int i = 0; i < 256; i++) dmem[i] = 8'($urandom);
        load(8'h90, 8'h44, 8'd240); run_frame(8'h90, 8'h44, 8'd240, "R4 max count");
        load(8'hA6, 8'h0C, 8'h10); run_frame(8'hA6, 8'h0C, 8'h10, "R5");
        load(8'h8F, 8'h13, 8'h00); run_frame(8'h8F, 8'h13, 8'h00, "R6");
        load(8'hAF, 8'h12, 8'h00); run_frame(8'hAF, 8'h12, 8'h00, "R6");
        load(8'hBA, 8'h05, 8'h00); run_frame(8'hBA, 8'h05, 8'h00, "R7");
        run_frame(8'h00, 8'h00, 8'h00, "R11");

        load(8'hA0, 8'h44, 8'h05);
        busy = 1'b1;
        run_frame(8'h01, 8'h00, 8'h00, "R3 busy");
        busy = 1'b0;
        run_frame(8'hA0, 8'h44, 8'h05, "R3 kept");

        load(8'h80, 8'h0C, 8'h04);
        open_sel(); pull(b); pull(b); pull(b); close_sel();
        run_frame(8'h80, 8'h0C, 8'h04, "R10 reread");
        run_frame(8'h00, 8'h00, 8'h00, "R11");

        load(8'hB4, 8'h44, 8'h08);
        for (int k = 0; k < 20; k++) begin
            byte_adv = 1'b1; @(negedge clk); byte_adv = 1'b0; @(negedge clk);
        end
        run_frame(8'hB4, 8'h44, 8'h08, "R12");

        for (int t = 0; t < 40; t++) begin
            logic [7:0] c = codes[$urandom_range(0, 14)];
            logic [7:0] inf = 8'($urandom);
            logic [7:0] n = 8'($urandom_range(0, 24));
            for (int i = 0; i < 32; i++) dmem[i] = 8'($urandom);
            load(c, inf, n);
            if (!c[7])             run_frame(c, inf, n, "R2 random");
            else if (is_read(c))   run_frame(c, inf, n, "R4 random");
            else if (c == 8'hBA)   run_frame(c, inf, n, "R7 random");
            else if (c == 8'h8F || c == 8'hAF) run_frame(c, inf, n, "R6 random");
            else                   run_frame(c, inf, n, "R5 random");
            if (t % 4 == 0) run_frame(8'h00, 8'h00, 8'h00, "R11 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule